// File: doc/BRIEF.md
# Prescaled Watchdog Timer

This block is a watchdog counter for a small microcontroller. Software must strike a clear strobe at regular intervals. If it fails to do so, the block emits a one-cycle timeout pulse that the reset logic outside it can act on. The watchdog counts ticks from one of two sources:

- a free-running tick that keeps arriving while the system clock is halted;
- the instruction tick, which runs at one quarter of the system clock.

Both arrive as single-cycle enables that are synchronous to the block clock.

The period is built from two parts. A fixed 256-step binary divider comes first. A power-of-two prescaler follows it, and a 3-bit select field in a small setting register programs the prescaler, so the period spans 256 up to 32768 ticks. Two configuration inputs are captured while reset is held and stay frozen afterwards: one chooses the tick source, and one enables the watchdog. With the watchdog disabled, clears, register writes and ticks all do nothing.

Top module: `wdog_timer`

## Requirements
- R1: While reset is held and after it is released, timeoutPulse is 0 and regRdData reads 0, so the select field starts at 0.
- R2: With select value 0, timeoutPulse goes high for the first time in the cycle that follows the clock edge at which the 256th counted tick since the restart is sampled.
- R3: With select value S (the unsigned value of regWrData bits 2:0 at the last accepted write), the timeout period is 256 * 2^S counted ticks, so S=7 gives 32768 ticks.
- R4: timeoutPulse lasts exactly one cycle. After it, counting restarts from zero, and the next pulse needs a further full period.
- R5: A clearStb cycle resets the whole count to zero. If a tick arrives in the same cycle as the clear, that tick is discarded.
- R6: A regWrEn cycle loads the select field from regWrData bits 2:0, which sets the new period at once. The same cycle clears the count, so the new period is measured from the write.
- R7: regRdData bits 2:0 return the select field, and bits 7:3 always read 0 whatever was written to them.
- R8: If cfgSrcSel is 1 while reset is held, only freeTick is counted. If it is 0, only instrTick is counted. Changes to cfgSrcSel or cfgEnable after reset is released have no effect.
- R9: If cfgEnable is 0 while reset is held, no timeout pulse is ever produced. Writes are ignored, so regRdData stays 0, and clears do nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Synchronous active-low reset; configuration is captured while low |
| freeTick | input | 1 | Free-running tick enable, one cycle wide |
| instrTick | input | 1 | Instruction tick enable, one cycle wide |
| cfgSrcSel | input | 1 | Tick source choice: 1 selects freeTick, 0 selects instrTick |
| cfgEnable | input | 1 | Watchdog enable, 1 = active |
| regWrEn | input | 1 | Write strobe for the setting register |
| regWrData | input | 8 | Write data; bits 2:0 hold the select field |
| clearStb | input | 1 | Software clear strobe |
| regRdData | output | 8 | Setting register readback |
| timeoutPulse | output | 1 | One-cycle expiry pulse |

## Verification
The bench counts the exact tick on which the period expires, for the smallest and the largest select value. A divider that is off by one stage would pulse a tick early or late, or at half or double the period. It strikes a clear and a tick in the same cycle, and writes the select field partway through a count. A design that let that tick through, or kept the old count across a write, would time out one tick early or measure the new period from the wrong point. After reset it changes the source and enable inputs and drives the unselected tick on its own; a design that kept sampling the configuration, or counted the wrong source, would pulse when it should stay quiet. The disabled run aims writes that set the upper register bits and a stream of clears at a block that must stay inert.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic advance; // count one selected tick
    logic restart; // zero the whole count
  } wdStrobe_t;
endpackage

// File: rtl/wdog_datapath.sv
module wdog_datapath
  import wdog_pkg::*;
#(
  parameter int BASE_STAGES = 8,
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  wdStrobe_t        strobe,
  input  logic [SEL_W-1:0] selVal,
  output logic             expire
);
  localparam int PRE_MAX = (1 << SEL_W) - 1;
  localparam int STAGES  = BASE_STAGES + PRE_MAX;

  logic [STAGES-1:0] cnt;
  logic [STAGES-1:0] cntNext;
  logic [STAGES:0]   carry;

  assign carry[0] = strobe.advance;

  // Ripple divider: each stage toggles when every stage below is set
  genvar i;
  generate
    for (i = 0; i < STAGES; i++) begin : g_stage
      assign carry[i+1]  = carry[i] & cnt[i];
      assign cntNext[i]  = cnt[i] ^ carry[i];
    end
  endgenerate

  // Expiry: carry into the first stage beyond the programmed period
  assign expire = carry[BASE_STAGES + int'(selVal)];

  always_ff @(posedge clk) begin
    if (!rstN || strobe.restart || expire) cnt <= '0;
    else                                   cnt <= cntNext;
  end

  // R3: expiry only on a counted tick
  assert_expire_on_tick_R3: assert property (@(posedge clk) disable iff (!rstN)
    expire |-> strobe.advance);

  // R3: count never reaches past the programmed period
  assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rstN)
    (cnt >> (BASE_STAGES + int'(selVal))) == '0);

  // R4: counting restarts from zero after expiry
  assert_restart_after_expire_R4: assert property (@(posedge clk) disable iff (!rstN)
    expire |=> cnt == '0);

  // R5: a restart strobe leaves the count at zero
  assert_restart_clears_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.restart |=> cnt == '0);
endmodule

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
  import wdog_pkg::*;
#(
  parameter int SEL_W = 3,
  parameter int REG_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             freeTick,
  input  logic             instrTick,
  input  logic             cfgSrcSel,
  input  logic             cfgEnable,
  input  logic             regWrEn,
  input  logic [REG_W-1:0] regWrData,
  input  logic             clearStb,
  input  logic             expire,
  output wdStrobe_t        strobe,
  output logic [SEL_W-1:0] selVal,
  output logic [REG_W-1:0] regRdData,
  output logic             timeoutPulse
);
  logic srcLatched;
  logic enLatched;
  logic tickSel;

  // Configuration follows the inputs only while reset is held
  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcLatched <= cfgSrcSel;
      enLatched  <= cfgEnable;
    end
  end

  assign tickSel        = srcLatched ? freeTick : instrTick;
  assign strobe.restart = enLatched & (clearStb | regWrEn);
  assign strobe.advance = enLatched & tickSel & ~strobe.restart;

  always_ff @(posedge clk) begin
    if (!rstN)                      selVal <= '0;
    else if (enLatched && regWrEn)  selVal <= regWrData[SEL_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) timeoutPulse <= 1'b0;
    else       timeoutPulse <= expire;
  end

  always_comb begin
    regRdData              = '0;
    regRdData[SEL_W-1:0]   = selVal;
  end

  // R4: the pulse never lasts two cycles
  assert_pulse_single_R4: assert property (@(posedge clk) disable iff (!rstN)
    timeoutPulse |=> !timeoutPulse);

  // R9: a disabled watchdog stays silent
  assert_disabled_quiet_R9: assert property (@(posedge clk) disable iff (!rstN)
    !enLatched |-> !timeoutPulse);

  // R6: an accepted write lands in the select field
  assert_write_loads_R6: assert property (@(posedge clk) disable iff (!rstN)
    (enLatched && regWrEn) |=> selVal == $past(regWrData[SEL_W-1:0]));

  // R8: configuration frozen outside reset
  assert_cfg_frozen_R8: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ($stable(srcLatched) && $stable(enLatched)));
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdog_pkg::*;
#(
  parameter int BASE_STAGES = 8,
  parameter int SEL_W = 3,
  parameter int REG_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             freeTick,
  input  logic             instrTick,
  input  logic             cfgSrcSel,
  input  logic             cfgEnable,
  input  logic             regWrEn,
  input  logic [REG_W-1:0] regWrData,
  input  logic             clearStb,
  output logic [REG_W-1:0] regRdData,
  output logic             timeoutPulse
);
  wdStrobe_t        strobe;
  logic [SEL_W-1:0] selVal;
  logic             expire;

  wdog_ctrl #(.SEL_W(SEL_W), .REG_W(REG_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .freeTick(freeTick), .instrTick(instrTick),
    .cfgSrcSel(cfgSrcSel), .cfgEnable(cfgEnable), .regWrEn(regWrEn),
    .regWrData(regWrData), .clearStb(clearStb), .expire(expire),
    .strobe(strobe), .selVal(selVal), .regRdData(regRdData),
    .timeoutPulse(timeoutPulse)
  );

  wdog_datapath #(.BASE_STAGES(BASE_STAGES), .SEL_W(SEL_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .selVal(selVal), .expire(expire)
  );
endmodule

// File: tb/sim_wdog_timer.sv
module sim_wdog_timer;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       freeTick = 1'b0, instrTick = 1'b0;
  logic       cfgSrcSel = 1'b1, cfgEnable = 1'b1;
  logic       regWrEn = 1'b0;
  logic [7:0] regWrData = 8'h00;
  logic       clearStb = 1'b0;
  logic [7:0] regRdData;
  logic       timeoutPulse;

  int checks = 0, failures = 0;
  bit done = 0;

  // model state
  bit          mEn, mSrc, mExp;
  int unsigned mCnt;
  logic [2:0]  mSel;

  always #5 clk = ~clk;

  wdog_timer u0 (
    .clk(clk), .rstN(rstN), .freeTick(freeTick), .instrTick(instrTick),
    .cfgSrcSel(cfgSrcSel), .cfgEnable(cfgEnable), .regWrEn(regWrEn),
    .regWrData(regWrData), .clearStb(clearStb), .regRdData(regRdData),
    .timeoutPulse(timeoutPulse)
  );

  function automatic int unsigned periodOf(logic [2:0] s);
    return 32'd256 << s;
  endfunction

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic doReset(bit src, bit en);
    rstN = 1'b0; cfgSrcSel = src; cfgEnable = en;
    freeTick = 0; instrTick = 0; regWrEn = 0; clearStb = 0; regWrData = 0;
    repeat (3) @(negedge clk);
    check("R1 pulse in reset", {7'd0, timeoutPulse}, 8'd0);
    rstN = 1'b1;
    mEn = en; mSrc = src; mCnt = 0; mSel = 0; mExp = 0;
    check("R1 pulse", {7'd0, timeoutPulse}, 8'd0);
    check("R1 readback", regRdData, 8'd0);
  endtask

  // Drive one cycle, advance the model, then compare
  task automatic cycle(bit ft, bit it, bit clr, bit wr, logic [7:0] d, string tag);
    bit tk;
    freeTick = ft; instrTick = it; clearStb = clr; regWrEn = wr; regWrData = d;
    tk = mEn && (mSrc ? ft : it);
    if (mEn && (clr || wr)) begin
      mCnt = 0; mExp = 0;
      if (wr) mSel = d[2:0];
    end else if (tk) begin
      if (mCnt == periodOf(mSel) - 1) begin mExp = 1; mCnt = 0; end
      else begin mCnt++; mExp = 0; end
    end else mExp = 0;
    @(negedge clk);
    check(tag, {7'd0, timeoutPulse}, {7'd0, mExp});
    check("R7 readback", regRdData, {5'd0, mSel});
  endtask

  function automatic bit pct(int p);
    return ($urandom % 100) < p;
  endfunction

  initial begin
    int unsigned seedDummy;
    seedDummy = $urandom(32'd20250611);
    // Phase A: free source, directed
    doReset(1'b1, 1'b1);
    for (int k = 0; k < 256; k++) cycle(1, pct(50), 0, 0, 0, "R2");
    for (int k = 0; k < 256; k++) cycle(1, 0, 0, 0, 0, "R4");
    for (int k = 0; k < 100; k++) cycle(1, 0, 0, 0, 0, "R5");
    cycle(1, 0, 1, 0, 0, "R5 clear with tick");
    for (int k = 0; k < 260; k++) cycle(1, 0, 0, 0, 0, "R5");
    for (int k = 0; k < 50; k++) cycle(1, 0, 0, 0, 0, "R6");
    cycle(0, 0, 0, 1, 8'hF9, "R6 write");
    check("R7 upper bits", regRdData, 8'h01);
    for (int k = 0; k < 1030; k++) cycle(1, 0, 0, 0, 0, "R6");
    // Phase B: random stimulus, small selects
    for (int k = 0; k < 8000; k++) begin
      bit wr = pct(1);
      cycle(pct(70), pct(50), pct(1) && !wr, wr, {5'($urandom), 3'($urandom % 3)}, "R3");
    end
    // Phase C: longest period, two expiries
    cycle(0, 0, 0, 1, 8'h07, "R3 write max");
    for (int k = 0; k < 65540; k++) cycle(1, 0, 0, 0, 0, "R3");
    // Phase D: instruction source, config changed after reset
    doReset(1'b0, 1'b1);
    cfgSrcSel = 1'b1; cfgEnable = 1'b0;
    for (int k = 0; k < 600; k++) cycle(1, 0, 0, 0, 0, "R8 unselected tick");
    for (int k = 0; k < 4000; k++) cycle(pct(60), pct(60), pct(1), 0, 0, "R8");
    // Phase E: disabled
    doReset(1'b1, 1'b0);
    cfgEnable = 1'b1;
    for (int k = 0; k < 3000; k++)
      cycle(1, 1, pct(5), pct(10), 8'($urandom), "R9");
    check("R9 readback", regRdData, 8'd0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule